// File: doc/BRIEF.md
# General-Purpose Event and SCI Combiner

This block keeps a small bank of general-purpose event (GPE) status and enable bytes and merges them with the fixed power-management event bits to produce one level-sensitive system control interrupt (SCI). Software reaches the bank through a byte-wide register port that covers a four-byte window. The lower half of the window holds the status bytes, which software clears by writing ones. The upper half holds the enable bytes, which are plain read/write.

Event sources raise status bits through a vector of one-cycle set pulses, one per status bit. By convention, bit 1 of status byte 0 is the PCI hotplug event and bit 2 is the CPU hotplug event. The fixed-event status and enable words come in on input buses. The block re-evaluates the SCI level on every clock, and so also after every register write and every set pulse.

The block also drives a registered request that asks an external periodic timer to arm itself. The timer counter is outside this block.

Top module: `gpe_sci_top`

## Requirements
- R1: After reset, all four register bytes read 0x00, and `sciLevel` and `tmrArmReq` are 0.
- R2: A write to offset 0 or 1 (status bytes 0 and 1) clears each status bit whose written data bit is 1. Data bits that are 0 leave their status bits unchanged. A read returns the current status byte.
- R3: A write to offset 2 or 3 loads enable byte 0 or 1 with the written data. A read of that offset returns the value written last.
- R4: A pulse on `evtSet[i]` sets status bit `i % 8` of status byte `i / 8` at the next clock edge. Bit 1 is the PCI hotplug event and bit 2 is the CPU hotplug event.
- R5: When a set pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: One cycle after (status byte 0 AND enable byte 0) has bit 1 or bit 2 set, `sciLevel` is 1. No other GPE bit, in either byte, can raise `sciLevel`.
- R7: One cycle after (`pm1Sts` AND `pm1En`) has bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (real-time clock) set, `sciLevel` is 1. Every other fixed-event bit is ignored.
- R8: `tmrArmReq` is 1 exactly one cycle after `pm1En[0]` was 1 while `pm1Sts[0]` was 0. Otherwise it is 0.
- R9: `sciLevel` is 0 one cycle after neither the GPE term of R6 nor the fixed-event term of R7 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 2 | Byte offset within the window |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| evtSet | input | 16 | One-cycle set pulses, one per status bit |
| pm1Sts | input | 16 | Fixed-event status word |
| pm1En | input | 16 | Fixed-event enable word |
| sciLevel | output | 1 | Registered SCI level |
| tmrArmReq | output | 1 | Registered request to arm the periodic timer |

## Verification
The assertions assume that `rstN` is low for at least one clock edge before any traffic. They also assume that the register port, the set pulses and the fixed-event words are stable around the rising edge. They treat `regAddr` as meaningful only when `regWrEn` is high. The stimulus meets these assumptions by driving every input one nanosecond after the rising edge and sampling on the falling edge. It also keeps reset low for several cycles at the start. The random phase combines set pulses, clearing writes to the same byte, enable rewrites and fixed-event word changes in the same cycles, so that the set-wins rule and the masking of the SCI are both exercised.

// File: rtl/gpe_sci_pkg.sv
package gpe_sci_pkg;

  localparam int BYTE_W = 8;

  // Strobes from the decode/control side to the register datapath.
  typedef struct packed {
    logic              stsWr;   // write-one-to-clear to a status byte
    logic              enWr;    // load of an enable byte
    logic              selHi;   // current offset is in the enable half
    logic [BYTE_W-1:0] wrByte;  // write data
  } regStrobe_t;

endpackage

// File: rtl/gpe_sci_ctrl.sv
module gpe_sci_ctrl
  import gpe_sci_pkg::*;
#(
  parameter int GPE_LEN = 4,
  parameter int PM1_W = 16,
  parameter logic [PM1_W-1:0] PM1_SCI_MASK = 16'h0521,
  parameter int TMR_BIT = 0,
  localparam int HALF = GPE_LEN / 2,
  localparam int ADDR_W = $clog2(GPE_LEN),
  localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWrData,
  input  logic              gpeHit,
  input  logic [PM1_W-1:0]  pm1Sts,
  input  logic [PM1_W-1:0]  pm1En,
  output regStrobe_t        strobe,
  output logic [IDX_W-1:0]  byteIdx,
  output logic              sciLevel,
  output logic              tmrArmReq
);

  logic              isHi;
  logic [ADDR_W-1:0] idxFull;
  logic              pm1Hit;

  // Offset decode: lower half is status, upper half is enable.
  always_comb begin
    isHi    = (regAddr >= ADDR_W'(HALF));
    idxFull = isHi ? (regAddr - ADDR_W'(HALF)) : regAddr;
    byteIdx = idxFull[IDX_W-1:0];

    strobe.stsWr  = regWrEn && !isHi;
    strobe.enWr   = regWrEn && isHi;
    strobe.selHi  = isHi;
    strobe.wrByte = regWrData;
  end

  assign pm1Hit = |(pm1Sts & pm1En & PM1_SCI_MASK);

  // Registered outputs, re-evaluated on every clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sciLevel  <= 1'b0;
      tmrArmReq <= 1'b0;
    end else begin
      sciLevel  <= gpeHit | pm1Hit;
      tmrArmReq <= pm1En[TMR_BIT] & ~pm1Sts[TMR_BIT];
    end
  end

endmodule

// File: rtl/gpe_sci_dpath.sv
module gpe_sci_dpath
  import gpe_sci_pkg::*;
#(
  parameter int GPE_LEN = 4,
  parameter logic [BYTE_W-1:0] GPE_SCI_MASK = 8'h06,
  localparam int HALF = GPE_LEN / 2,
  localparam int STS_W = HALF * BYTE_W,
  localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [STS_W-1:0]  evtSet,
  output logic [BYTE_W-1:0] rdData,
  output logic [STS_W-1:0]  stsFlat,
  output logic [STS_W-1:0]  enFlat,
  output logic              gpeHit
);

  logic [BYTE_W-1:0] stsReg [HALF];
  logic [BYTE_W-1:0] enReg  [HALF];

  for (genvar b = 0; b < HALF; b++) begin : g_byte
    logic              hitThis;
    logic [BYTE_W-1:0] clrMask;

    assign hitThis = (int'(byteIdx) == b);
    assign clrMask = (strobe.stsWr && hitThis) ? strobe.wrByte : '0;

    // Status: the set pulse is ORed in after the clear, so it wins.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stsReg[b] <= '0;
      else       stsReg[b] <= (stsReg[b] & ~clrMask) | evtSet[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       enReg[b] <= '0;
      else if (strobe.enWr && hitThis) enReg[b] <= strobe.wrByte;
    end

    assign stsFlat[b*BYTE_W +: BYTE_W] = stsReg[b];
    assign enFlat[b*BYTE_W +: BYTE_W]  = enReg[b];
  end

  assign rdData = strobe.selHi ? enReg[byteIdx] : stsReg[byteIdx];
  assign gpeHit = |(stsReg[0] & enReg[0] & GPE_SCI_MASK);

endmodule

// File: rtl/gpe_sci_top.sv
module gpe_sci_top
  import gpe_sci_pkg::*;
#(
  parameter int GPE_LEN = 4,
  parameter int PM1_W = 16,
  parameter logic [PM1_W-1:0] PM1_SCI_MASK = 16'h0521,
  parameter logic [7:0] GPE_SCI_MASK = 8'h06,
  parameter int TMR_BIT = 0,
  localparam int HALF = GPE_LEN / 2,
  localparam int STS_W = HALF * 8,
  localparam int ADDR_W = $clog2(GPE_LEN),
  localparam int IDX_W = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [STS_W-1:0]  evtSet,
  input  logic [PM1_W-1:0]  pm1Sts,
  input  logic [PM1_W-1:0]  pm1En,
  output logic              sciLevel,
  output logic              tmrArmReq
);

  regStrobe_t       strobe;
  logic [IDX_W-1:0] byteIdx;
  logic             gpeHit;
  logic [STS_W-1:0] stsFlat;
  logic [STS_W-1:0] enFlat;

  gpe_sci_ctrl #(
    .GPE_LEN(GPE_LEN), .PM1_W(PM1_W),
    .PM1_SCI_MASK(PM1_SCI_MASK), .TMR_BIT(TMR_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .gpeHit(gpeHit), .pm1Sts(pm1Sts), .pm1En(pm1En),
    .strobe(strobe), .byteIdx(byteIdx),
    .sciLevel(sciLevel), .tmrArmReq(tmrArmReq)
  );

  gpe_sci_dpath #(
    .GPE_LEN(GPE_LEN), .GPE_SCI_MASK(GPE_SCI_MASK)
  ) u_dpath (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .byteIdx(byteIdx), .evtSet(evtSet),
    .rdData(regRdData), .stsFlat(stsFlat), .enFlat(enFlat),
    .gpeHit(gpeHit)
  );

endmodule

// File: rtl/gpe_sci_chk.sv
module gpe_sci_chk #(
  parameter int GPE_LEN = 4,
  parameter int PM1_W = 16,
  parameter logic [PM1_W-1:0] PM1_SCI_MASK = 16'h0521,
  parameter logic [7:0] GPE_SCI_MASK = 8'h06,
  parameter int TMR_BIT = 0,
  localparam int HALF = GPE_LEN / 2,
  localparam int STS_W = HALF * 8,
  localparam int ADDR_W = $clog2(GPE_LEN)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        regWrData,
  input logic [STS_W-1:0]  evtSet,
  input logic [PM1_W-1:0]  pm1Sts,
  input logic [PM1_W-1:0]  pm1En,
  input logic [STS_W-1:0]  stsFlat,
  input logic [STS_W-1:0]  enFlat,
  input logic              sciLevel,
  input logic              tmrArmReq
);

  logic gpeTerm, pm1Term, tmrCond;
  assign gpeTerm = |(stsFlat[7:0] & enFlat[7:0] & GPE_SCI_MASK);
  assign pm1Term = |(pm1Sts & pm1En & PM1_SCI_MASK);
  assign tmrCond = pm1En[TMR_BIT] && !pm1Sts[TMR_BIT];

  a_r4_pci_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    evtSet[1] |=> stsFlat[1]);

  a_r4_cpu_set_lands: assert property (@(posedge clk) disable iff (!rstN)
    evtSet[2] |=> stsFlat[2]);

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == '0 && regWrData[1] && evtSet[1]) |=> stsFlat[1]);

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == '0 && regWrData[2] && !evtSet[2]) |=> !stsFlat[2]);

  a_r3_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(HALF)) |=> (enFlat[7:0] == $past(regWrData)));

  a_r6_gpe_raises: assert property (@(posedge clk) disable iff (!rstN)
    gpeTerm |=> sciLevel);

  a_r7_pm1_raises: assert property (@(posedge clk) disable iff (!rstN)
    pm1Term |=> sciLevel);

  a_r9_sci_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!gpeTerm && !pm1Term) |=> !sciLevel);

  a_r8_timer_arm: assert property (@(posedge clk) disable iff (!rstN)
    tmrCond |=> tmrArmReq);

  a_r8_timer_idle: assert property (@(posedge clk) disable iff (!rstN)
    !tmrCond |=> !tmrArmReq);

endmodule

bind gpe_sci_top gpe_sci_chk #(
  .GPE_LEN(GPE_LEN), .PM1_W(PM1_W), .PM1_SCI_MASK(PM1_SCI_MASK),
  .GPE_SCI_MASK(GPE_SCI_MASK), .TMR_BIT(TMR_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .evtSet(evtSet), .pm1Sts(pm1Sts), .pm1En(pm1En),
  .stsFlat(stsFlat), .enFlat(enFlat), .sciLevel(sciLevel), .tmrArmReq(tmrArmReq)
);

// File: tb/gpe_sci_top_test.sv
`timescale 1ns/1ps
module gpe_sci_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [15:0] evtSet = '0;
  logic [15:0] pm1Sts = '0;
  logic [15:0] pm1En = '0;
  logic        sciLevel, tmrArmReq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;
  bit cmpOn = 0;

  // Reference state
  logic [7:0] mSts [2] = '{8'h00, 8'h00};
  logic [7:0] mEn  [2] = '{8'h00, 8'h00};
  logic       mSci = 1'b0;
  logic       mTmr = 1'b0;

  always #2.5 clk = ~clk;

  gpe_sci_top uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .evtSet(evtSet),
    .pm1Sts(pm1Sts), .pm1En(pm1En), .sciLevel(sciLevel), .tmrArmReq(tmrArmReq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model, advanced on each rising edge.
  always @(posedge clk) begin
    if (!rstN) begin
      mSts[0] = 0; mSts[1] = 0; mEn[0] = 0; mEn[1] = 0; mSci = 0; mTmr = 0;
    end else begin
      bit gHit, pHit;
      gHit = ((mSts[0] & mEn[0]) & 8'h06) != 0;
      pHit = ((pm1Sts & pm1En) & 16'h0521) != 0;
      mSci = gHit || pHit;
      mTmr = pm1En[0] && !pm1Sts[0];
      for (int b = 0; b < 2; b++) begin
        if (regWrEn && regAddr == 2'(b)) mSts[b] = mSts[b] & ~regWrData;
        mSts[b] = mSts[b] | evtSet[b*8 +: 8];
        if (regWrEn && regAddr == 2'(b + 2)) mEn[b] = regWrData;
      end
    end
  end

  // Cycle comparison on the falling edge.
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      logic [7:0] expRd;
      expRd = (regAddr < 2) ? mSts[regAddr[0]] : mEn[regAddr[0]];
      check("R6/R7/R9 sciLevel", int'(sciLevel), int'(mSci));
      check("R8 tmrArmReq", int'(tmrArmReq), int'(mTmr));
      check("R2/R3 regRdData", int'(regRdData), int'(expRd));
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    regWrEn = 0; evtSet = '0;
    for (int i = 0; i < n; i++) cyc();
    regWrEn = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    cyc();
    regWrEn = 0;
  endtask

  task automatic pulse(input logic [15:0] s);
    evtSet = s;
    cyc();
    evtSet = '0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] a, input logic [7:0] exp);
    regAddr = a;
    @(negedge clk);
    check(req, int'(regRdData), int'(exp));
    cyc();
  endtask

  task automatic sciChk(input string req, input logic exp);
    idle(2);
    @(negedge clk);
    check(req, int'(sciLevel), int'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) cyc();
    // R1: state during and right after reset
    @(negedge clk);
    check("R1 sciLevel", int'(sciLevel), 0);
    check("R1 tmrArmReq", int'(tmrArmReq), 0);
    rstN = 1;
    cyc();
    cmpOn = 1;
    for (int a = 0; a < 4; a++) rdChk("R1 reset byte", 2'(a), 8'h00);

    // R3: enable read/write
    wr(2'd2, 8'h06);
    wr(2'd3, 8'hA5);
    rdChk("R3 enable byte0", 2'd2, 8'h06);
    rdChk("R3 enable byte1", 2'd3, 8'hA5);

    // R4/R6: PCI hotplug pulse raises SCI
    pulse(16'h0002);
    rdChk("R4 pci status", 2'd0, 8'h02);
    sciChk("R6 sci from pci hotplug", 1'b1);

    // R2/R9: clear, SCI drops; writing zeros leaves status alone
    pulse(16'h0004);
    wr(2'd0, 8'h00);
    rdChk("R2 zero write keeps", 2'd0, 8'h06);
    wr(2'd0, 8'h06);
    rdChk("R2 w1c clears", 2'd0, 8'h00);
    sciChk("R9 sci low after clear", 1'b0);

    // R6: other bits masked even when enabled
    wr(2'd2, 8'hF9);
    wr(2'd3, 8'hFF);
    pulse(16'hFFF9);
    rdChk("R4 byte1 status", 2'd1, 8'hFF);
    sciChk("R6 non-hotplug bits ignored", 1'b0);

    // R5: set and clear in the same cycle
    wr(2'd0, 8'hFF);
    regWrEn = 1; regAddr = 2'd0; regWrData = 8'h04; evtSet = 16'h0004;
    cyc();
    regWrEn = 0; evtSet = '0;
    rdChk("R5 set wins", 2'd0, 8'h04);
    wr(2'd0, 8'h04);

    // R7: fixed-event sources
    pm1En = 16'hFFFF;
    pm1Sts = 16'hFADE;
    sciChk("R7 other pm1 bits ignored", 1'b0);
    pm1Sts = 16'h0001; sciChk("R7 timer source", 1'b1);
    pm1Sts = 16'h0020; sciChk("R7 global lock source", 1'b1);
    pm1Sts = 16'h0100; sciChk("R7 power button source", 1'b1);
    pm1Sts = 16'h0400; sciChk("R7 rtc source", 1'b1);
    pm1En = 16'hFBFF; sciChk("R7 rtc masked by enable", 1'b0);

    // R8: timer arm request
    pm1En = 16'h0001; pm1Sts = 16'h0000;
    idle(2); @(negedge clk); check("R8 arm when enabled", int'(tmrArmReq), 1);
    pm1Sts = 16'h0001;
    idle(2); @(negedge clk); check("R8 no arm when status set", int'(tmrArmReq), 0);
    pm1En = 16'h0000; pm1Sts = 16'h0000;
    idle(2); @(negedge clk); check("R8 no arm when disabled", int'(tmrArmReq), 0);

    // Mixed random traffic, checked each cycle against the model
    for (int i = 0; i < 3000; i++) begin
      regWrEn   = ($urandom % 3) == 0;
      regAddr   = 2'($urandom);
      regWrData = 8'($urandom);
      evtSet    = 16'($urandom & $urandom & $urandom);
      if (($urandom % 8) == 0) pm1Sts = 16'($urandom & $urandom);
      if (($urandom % 8) == 0) pm1En = 16'($urandom);
      cyc();
    end
    idle(3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule